// File: doc/BRIEF.md
# Byte-Lane Controller for an Asynchronous 16-bit SRAM

This block sits between a clocked host and an external asynchronous static RAM that is 16 bits wide and has two byte lanes. The host issues single-cycle requests over a valid/ready handshake. Each request carries a read/write flag, an address, write data and a two-bit lane mask. The controller turns each request into a timed sequence on the memory's active-low select, output-enable, write-enable and per-lane enables. It also drives a split data bus: data out, a driver enable for the pad, and data in.

Every memory timing window is a whole number of clock cycles, set by parameters:

- the read access wait;
- the write pulse width;
- the bus turnaround.

A build-time switch picks the write style:

- **Output enable high during writes.** The write pulse is the minimum width.
- **Output enable held low during writes.** The pulse is extended by the turnaround time. The controller keeps its drivers off for the first part of the pulse, so the memory's outputs have time to turn off before the controller places data.

Read data comes back with a one-cycle valid strobe, and lanes that were not requested read as zero. A request whose mask selects no lane finishes at once and touches no memory pin. When a write follows a read, a dead turnaround period is inserted between them.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, select, output enable, write enable and both lane enables are high, the data driver enable is low, the response strobe is low and ready is high.
- R2: A read with a non-zero mask holds select and output enable low and write enable high for exactly ACCESS_CYC cycles. Ready is low for exactly those cycles. The response strobe is high for one cycle, in the cycle after the last access cycle.
- R3: Read data is taken from the memory data input in the last access cycle. Lanes not selected by the mask return zero.
- R4: With the output-enable-high write style, a write holds select and write enable low, with output enable high, for exactly WP_CYC cycles, and drives the request's write data in every one of those cycles.
- R5: With the output-enable-low write style, a write holds select, write enable and output enable low for TURN_CYC+WP_CYC cycles. The data drivers stay off for the first TURN_CYC of those cycles and are on for the last WP_CYC.
- R6: Mask bit 0 selects the lower lane (data bits 7:0, lower lane enable). Mask bit 1 selects the upper lane (bits 15:8, upper lane enable). Each lane enable is low during a cycle exactly when its mask bit is 1, and a single-lane write leaves the other lane of the word unchanged.
- R7: A write whose previous non-empty request was a read waits TURN_CYC cycles after acceptance with every memory control high and the drivers off before its write pulse starts. A write after a write starts without that wait.
- R8: The controller never enables its data drivers while output enable is low and write enable is high.
- R9: Ready stays low from the cycle after acceptance until the memory cycle ends. Write enable is low only while select and at least one lane enable are low.
- R10: A request with an all-zero mask issues no memory cycle and keeps ready high. As a read, it returns the strobe in the next cycle with data zero. It does not change the turnaround state left by the previous request.
- R11: The memory address stays constant for the whole time select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | 2 | Lane mask, bit 0 lower lane, bit 1 upper lane |
| req_ready | output | 1 | Controller idle and able to accept |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read data, unselected lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_dq_o | output | DATA_W | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_i | input | DATA_W | Data from the memory |

## Verification
A fixed vector table runs full-word, lower-only and upper-only writes and reads against a bench memory model. That model returns a filler pattern on any lane it was not asked for, so it catches both a swapped lane mapping and a missing zero fill. Writes to one lane between reads of both lanes show whether the other lane is preserved. Mixing read-to-write, write-to-write and empty-mask orderings separates a turnaround that is inserted correctly from one that is missing or always present. A second instance, built with output enable held low during writes and a longer turnaround, measures the extended pulse and the late driver start.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 16,
  parameter int ACCESS_CYC   = 2,
  parameter int WP_CYC       = 2,
  parameter int TURN_CYC     = 1,
  parameter bit OE_LOW_WRITE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int LANE_W = DATA_W / 2;
  localparam int WR_LEN = OE_LOW_WRITE ? TURN_CYC + WP_CYC : WP_CYC;
  localparam int CNT_W  = $clog2(ACCESS_CYC + TURN_CYC + WP_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_TURN, S_READ, S_WRITE} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]       be_q;
  logic             last_rd;
  logic [DATA_W-1:0] lane_mask;

  assign req_ready = (st == S_IDLE);
  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign lane_mask = {{LANE_W{be_q[1]}}, {LANE_W{be_q[0]}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      last_rd   <= 1'b0;
      mem_cs_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_ub_n  <= 1'b1;
      mem_lb_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            if (req_be == 2'b00) begin
              if (!req_write) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= '0;
              end
            end else begin
              addr_q  <= req_addr;
              wdata_q <= req_wdata;
              be_q    <= req_be;
              if (!req_write) begin
                st       <= S_READ;
                cnt      <= CNT_W'(ACCESS_CYC - 1);
                last_rd  <= 1'b1;
                mem_cs_n <= 1'b0;
                mem_oe_n <= 1'b0;
                mem_ub_n <= !req_be[1];
                mem_lb_n <= !req_be[0];
              end else if (last_rd) begin
                st      <= S_TURN;
                cnt     <= CNT_W'(TURN_CYC - 1);
                last_rd <= 1'b0;
              end else begin
                st        <= S_WRITE;
                cnt       <= CNT_W'(WR_LEN - 1);
                mem_cs_n  <= 1'b0;
                mem_we_n  <= 1'b0;
                mem_oe_n  <= !OE_LOW_WRITE;
                mem_ub_n  <= !req_be[1];
                mem_lb_n  <= !req_be[0];
                mem_dq_oe <= !OE_LOW_WRITE;
              end
            end
          end
        end
        S_TURN: begin
          if (cnt == '0) begin
            st        <= S_WRITE;
            cnt       <= CNT_W'(WR_LEN - 1);
            mem_cs_n  <= 1'b0;
            mem_we_n  <= 1'b0;
            mem_oe_n  <= !OE_LOW_WRITE;
            mem_ub_n  <= !be_q[1];
            mem_lb_n  <= !be_q[0];
            mem_dq_oe <= !OE_LOW_WRITE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_READ: begin
          if (cnt == '0) begin
            st        <= S_IDLE;
            rsp_valid <= 1'b1;
            rsp_rdata <= mem_dq_i & lane_mask;
            mem_cs_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_ub_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WRITE: begin
          if (cnt == '0) begin
            st        <= S_IDLE;
            mem_cs_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_ub_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(WP_CYC)) mem_dq_oe <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n && mem_we_n));

  a_r9_write_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && (!mem_ub_n || !mem_lb_n)));

  a_r9_busy_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);

  a_r11_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r6_lanes_follow_select: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_ub_n && mem_lb_n && mem_we_n && mem_oe_n));

endmodule

// File: tb/sram_lane_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb_top;
  localparam int ACC  = 3;
  localparam int WP   = 2;
  localparam int TRN  = 1;
  localparam int TRN2 = 2;
  localparam int NV   = 17;

  // vector: {write, addr, wdata, mask, expected read data}
  localparam logic [50:0] VEC [NV] = '{
    {1'b1, 16'h0010, 16'h1234, 2'b11, 16'h0000},
    {1'b0, 16'h0010, 16'h0000, 2'b11, 16'h1234},
    {1'b1, 16'h0010, 16'hAB99, 2'b01, 16'h0000},
    {1'b0, 16'h0010, 16'h0000, 2'b11, 16'h1299},
    {1'b1, 16'h0010, 16'h77CC, 2'b10, 16'h0000},
    {1'b0, 16'h0010, 16'h0000, 2'b10, 16'h7700},
    {1'b0, 16'h0010, 16'h0000, 2'b01, 16'h0099},
    {1'b1, 16'hFFFF, 16'hBEEF, 2'b11, 16'h0000},
    {1'b1, 16'h0000, 16'h0F0F, 2'b11, 16'h0000},
    {1'b0, 16'hFFFF, 16'h0000, 2'b11, 16'hBEEF},
    {1'b0, 16'h0000, 16'h0000, 2'b11, 16'h0F0F},
    {1'b1, 16'h0010, 16'hFFFF, 2'b00, 16'h0000},
    {1'b0, 16'h0010, 16'h0000, 2'b11, 16'h7799},
    {1'b0, 16'h0010, 16'h0000, 2'b00, 16'h0000},
    {1'b1, 16'h0020, 16'h5A5A, 2'b11, 16'h0000},
    {1'b0, 16'h0020, 16'h0000, 2'b11, 16'h5A5A},
    {1'b0, 16'h0020, 16'h0000, 2'b10, 16'h5A00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_o, mem_dq_i;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;

  logic        r2_valid = 1'b0, r2_write = 1'b0;
  logic [15:0] r2_addr = '0, r2_wdata = '0;
  logic [1:0]  r2_be = '0;
  logic        r2_ready, r2_rsp_valid;
  logic [15:0] r2_rdata, r2_maddr, r2_dq_o;
  logic        r2_cs_n, r2_oe_n, r2_we_n, r2_ub_n, r2_lb_n, r2_dq_oe;

  sram_lane_ctrl #(.ACCESS_CYC(ACC), .WP_CYC(WP), .TURN_CYC(TRN), .OE_LOW_WRITE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i));

  sram_lane_ctrl #(.ACCESS_CYC(ACC), .WP_CYC(WP), .TURN_CYC(TRN2), .OE_LOW_WRITE(1'b1)) dut_oe_i (
    .clk(clk), .rst_n(rst_n), .req_valid(r2_valid), .req_write(r2_write),
    .req_addr(r2_addr), .req_wdata(r2_wdata), .req_be(r2_be), .req_ready(r2_ready),
    .rsp_valid(r2_rsp_valid), .rsp_rdata(r2_rdata), .mem_addr(r2_maddr), .mem_cs_n(r2_cs_n),
    .mem_oe_n(r2_oe_n), .mem_we_n(r2_we_n), .mem_ub_n(r2_ub_n), .mem_lb_n(r2_lb_n),
    .mem_dq_o(r2_dq_o), .mem_dq_oe(r2_dq_oe), .mem_dq_i(16'h0000));

  // memory model: 256 words, filler A5 on lanes not requested
  logic [15:0] mem [256];
  logic        pend = 1'b0;
  logic [7:0]  pa;
  logic [15:0] pd;
  logic [1:0]  pl;
  wire rd_on = !mem_cs_n && !mem_oe_n && mem_we_n;
  assign mem_dq_i = rd_on ? {(!mem_ub_n ? mem[mem_addr[7:0]][15:8] : 8'hA5),
                             (!mem_lb_n ? mem[mem_addr[7:0]][7:0]  : 8'hA5)} : 16'hFFFF;

  always @(negedge clk) begin
    if (!mem_cs_n && !mem_we_n && (!mem_ub_n || !mem_lb_n)) begin
      pend <= 1'b1;
      pa   <= mem_addr[7:0];
      pl   <= {!mem_ub_n, !mem_lb_n};
      if (mem_dq_oe) pd <= mem_dq_o;
    end else if (pend) begin
      pend <= 1'b0;
      if (pl[1]) mem[pa][15:8] <= pd[15:8];
      if (pl[0]) mem[pa][7:0]  <= pd[7:0];
    end
  end

  int n_chk = 0, n_fail = 0, clash = 0;
  bit done = 1'b0;

  always @(negedge clk)
    if (rst_n && ((mem_dq_oe && !mem_oe_n && mem_we_n) || (r2_dq_oe && !r2_oe_n && r2_we_n)))
      clash++;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic do_req(input logic wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] be,
                        output int busy, output int gap, output int rdc, output int wec, output int drvc,
                        output bit got, output logic [15:0] rd, output bit addr_ok, output bit data_ok,
                        output logic [1:0] lanes_n);
    bit seen = 1'b0;
    logic [15:0] fa = '0;
    busy = 0; gap = 0; rdc = 0; wec = 0; drvc = 0; got = 1'b0; rd = '0;
    addr_ok = 1'b1; data_ok = 1'b1; lanes_n = 2'b11;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (rsp_valid) begin got = 1'b1; rd = rsp_rdata; end
      if (!req_ready) busy++;
      if (!mem_cs_n) begin
        if (!seen) begin fa = mem_addr; lanes_n = {mem_ub_n, mem_lb_n}; end
        seen = 1'b1;
        if (mem_addr != fa) addr_ok = 1'b0;
        if ({mem_ub_n, mem_lb_n} != lanes_n) addr_ok = 1'b0;
        if (!mem_oe_n && mem_we_n) rdc++;
        if (!mem_we_n) wec++;
        if (mem_dq_oe) begin drvc++; if (mem_dq_o != d) data_ok = 1'b0; end
      end else if (!req_ready && !seen) begin
        gap++;
        if (mem_dq_oe || !mem_oe_n || !mem_we_n || !mem_ub_n || !mem_lb_n) gap += 100;
      end
      if (req_ready) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int busy, gap, rdc, wec, drvc;
    bit got, aok, dok;
    logic [15:0] rd;
    logic [1:0] ln;
    bit prev_rd;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n} == 5'b11111, "R1 controls", 
        {27'd0, mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, 32'h1f);
    chk(!mem_dq_oe && !rsp_valid && req_ready, "R1 drivers/strobe/ready",
        {29'd0, mem_dq_oe, rsp_valid, req_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk({mem_cs_n, mem_we_n, mem_dq_oe, req_ready} == 4'b1101, "R1 after release",
        {28'd0, mem_cs_n, mem_we_n, mem_dq_oe, req_ready}, 32'hd);

    prev_rd = 1'b0;
    for (int v = 0; v < NV; v++) begin
      logic        w;
      logic [15:0] a, d, e;
      logic [1:0]  be;
      {w, a, d, be, e} = VEC[v];
      do_req(w, a, d, be, busy, gap, rdc, wec, drvc, got, rd, aok, dok, ln);
      if (be == 2'b00) begin
        chk(busy == 0 && rdc == 0 && wec == 0, "R10 no memory cycle", busy + rdc + wec, 0);
        chk(got == !w, "R10 strobe", {31'd0, got}, {31'd0, !w});
        if (!w) chk(rd == 16'h0000, "R10 zero data", {16'd0, rd}, 0);
      end else if (!w) begin
        chk(rdc == ACC && busy == ACC, "R2 access length", rdc * 256 + busy, ACC * 256 + ACC);
        chk(wec == 0 && drvc == 0 && gap == 0, "R8 no drive on read", wec + drvc + gap, 0);
        chk(got, "R2 strobe", {31'd0, got}, 1);
        chk(rd == e, "R3 read data", {16'd0, rd}, {16'd0, e});
        chk(ln == ~be, "R6 lane enables", {30'd0, ln}, {30'd0, ~be});
        chk(aok, "R11 address stable", {31'd0, aok}, 1);
        prev_rd = 1'b1;
      end else begin
        chk(gap == (prev_rd ? TRN : 0), "R7 turnaround", gap, prev_rd ? TRN : 0);
        chk(wec == WP && drvc == WP && rdc == 0, "R4 write pulse", wec * 256 + drvc, WP * 256 + WP);
        chk(busy == gap + WP, "R9 busy window", busy, gap + WP);
        chk(dok && aok, "R11 data/address stable", {30'd0, dok, aok}, 3);
        chk(ln == ~be && !got, "R6 write lanes", {29'd0, got, ln}, {30'd0, ~be});
        prev_rd = 1'b0;
      end
    end

    // R5: output-enable-low write style on the second instance
    begin
      int wec2 = 0, drv2 = 0, oel = 0, lead = 0, gap2 = 0;
      bit seen2 = 1'b0, started = 1'b0;
      @(negedge clk);
      r2_valid = 1'b1; r2_write = 1'b0; r2_addr = 16'h0005; r2_be = 2'b11;
      @(negedge clk);
      r2_valid = 1'b0;
      for (int i = 0; i < 64 && !r2_ready; i++) @(negedge clk);
      r2_valid = 1'b1; r2_write = 1'b1; r2_wdata = 16'hC3C3; r2_be = 2'b01;
      for (int i = 0; i < 64; i++) begin
        @(negedge clk);
        r2_valid = 1'b0;
        if (!r2_we_n) begin
          seen2 = 1'b1;
          wec2++;
          if (!r2_oe_n) oel++;
          if (r2_dq_oe) begin started = 1'b1; drv2++; end
          else if (!started) lead++;
        end else if (!r2_ready && !seen2) gap2++;
        if (r2_ready) break;
      end
      chk(wec2 == TRN2 + WP, "R5 extended pulse", wec2, TRN2 + WP);
      chk(oel == TRN2 + WP, "R5 output enable low", oel, TRN2 + WP);
      chk(drv2 == WP && lead == TRN2, "R5 late drive", drv2 * 256 + lead, WP * 256 + TRN2);
      chk(gap2 == TRN2, "R7 turnaround wide", gap2, TRN2);
    end

    chk(clash == 0, "R8 driver clash", clash, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule